// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the 13-bit instruction address of a small processor core and works out the next one each cycle. The address can advance by one. It can take a computed value in its low byte. It can jump or call within a 2K page. It can return from a subroutine or enter an interrupt at a fixed vector. An instruction decoder drives the strobes. The memory system reads the fetch address, which is the PC reduced modulo the implemented program size.

The upper five PC bits cannot be loaded directly. They come from a 5-bit holding latch that software writes and reads back. A low-byte write copies the whole latch into the top bits. A jump or call copies only latch bits 4:3, which select the page. An 8-entry return stack stores full 13-bit return addresses. The stack pointer wraps in both directions, and nothing reports an overflow.

Top module: `pcu_top`

## Requirements
- R1: After synchronous reset the PC is 0000h, the holding latch is 00h and the stack pointer is 0.
- R2: With only the advance strobe active, the PC becomes PC+1 modulo 2^13, so 1FFFh wraps to 0000h.
- R3: A low-byte write loads the PC with {holding latch[4:0], data[7:0]}. The latch value used is the one held before that clock edge.
- R4: A jump loads the PC with {holding latch[4:3], target[10:0]} and leaves the stack untouched.
- R5: A call does what a jump does and also pushes PC+1 as the return address.
- R6: An interrupt request pushes the current PC and loads the PC with 0004h.
- R7: A return loads the PC with the most recently pushed entry and removes that entry.
- R8: The stack has 8 entries of 13 bits. A ninth push overwrites the entry of the first push, a tenth overwrites the second, and so on. A pop from an empty stack wraps and returns the entry the pointer then selects.
- R9: A latch write stores data[4:0], and the readback port shows it on the next cycle. Jumps, calls, returns and interrupts never change the latch.
- R10: The fetch address is the low log2(MEM_WORDS) bits of the PC, so addresses above the implemented memory wrap.
- R11: When several strobes are active together, the priority is interrupt, then return, then jump/call, then low-byte write, then advance. Only the winner has any effect on the PC or the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance the PC by one |
| lo_we | input | 1 | Write the PC low byte |
| lo_data | input | 8 | Low-byte write data |
| br_en | input | 1 | Jump or call strobe |
| br_link | input | 1 | With br_en: push a return address (call) |
| br_tgt | input | 11 | Jump or call target within the page |
| ret_en | input | 1 | Return: pop the stack into the PC |
| irq_en | input | 1 | Interrupt entry: push the PC, go to 0004h |
| hold_we | input | 1 | Holding-latch write strobe |
| hold_data | input | 5 | Holding-latch write data |
| pc_q | output | 13 | Current program counter |
| fetch_addr | output | log2(MEM_WORDS) | PC wrapped to the implemented memory |
| hold_q | output | 5 | Holding-latch readback |

## Verification
The bench builds the block with MEM_WORDS = 1024. With that size, a fetch-address wrap already appears when the PC reaches 0400h, which takes only a few latch writes. The stack depth stays at its default of 8, so nine calls followed by nine returns cover both the overwrite of the oldest entry and the pop from an empty stack. A table of mixed operations runs the page-select path through latch values whose bits 4:3 are nonzero. Directed steps then raise several strobes together to confirm the priority order.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int PC_W   = 13;
  localparam int LO_W   = 8;
  localparam int HI_W   = PC_W - LO_W;
  localparam int TGT_W  = 11;
  localparam int PAGE_W = PC_W - TGT_W;
  localparam logic [PC_W-1:0] RESET_VEC = 13'h0000;
  localparam logic [PC_W-1:0] IRQ_VEC   = 13'h0004;
endpackage

// File: rtl/pcu_rstack.sv
module pcu_rstack #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top_val
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] sp;
  logic [PTR_W-1:0] sp_dec;

  assign sp_dec  = sp - PTR_W'(1);
  assign top_val = mem[sp_dec];

  // Storage has no reset so it can map onto a small RAM.
  always_ff @(posedge clk) begin
    if (push) mem[sp] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (rst)       sp <= '0;
    else if (push) sp <= sp + PTR_W'(1);
    else if (pop)  sp <= sp_dec;
  end

  // R8: the pointer wraps in both directions
  a_r8_push_wrap: assert property (@(posedge clk) disable iff (rst)
    push |=> sp == $past(sp) + PTR_W'(1));
  a_r8_pop_wrap: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> sp == $past(sp) - PTR_W'(1));
  // R11: the selector never pushes and pops in one cycle
  a_r11_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({push, pop}));
endmodule

// File: rtl/pcu_sel.sv
module pcu_sel
  import pcu_pkg::*;
(
  input  logic [PC_W-1:0]  pc_q,
  input  logic [HI_W-1:0]  hold_q,
  input  logic             adv_en,
  input  logic             lo_we,
  input  logic [LO_W-1:0]  lo_data,
  input  logic             br_en,
  input  logic             br_link,
  input  logic [TGT_W-1:0] br_tgt,
  input  logic             ret_en,
  input  logic             irq_en,
  input  logic [PC_W-1:0]  pop_val,
  output logic [PC_W-1:0]  pc_nxt,
  output logic             push,
  output logic             pop,
  output logic [PC_W-1:0]  push_val
);
  logic [PC_W-1:0] pc_inc;
  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    pc_nxt   = pc_q;
    push     = 1'b0;
    pop      = 1'b0;
    push_val = pc_q;
    if (irq_en) begin
      push   = 1'b1;
      pc_nxt = IRQ_VEC;
    end else if (ret_en) begin
      pop    = 1'b1;
      pc_nxt = pop_val;
    end else if (br_en) begin
      pc_nxt = {hold_q[HI_W-1 -: PAGE_W], br_tgt};
      if (br_link) begin
        push     = 1'b1;
        push_val = pc_inc;
      end
    end else if (lo_we) begin
      pc_nxt = {hold_q, lo_data};
    end else if (adv_en) begin
      pc_nxt = pc_inc;
    end
  end
endmodule

// File: rtl/pcu_top.sv
module pcu_top
  import pcu_pkg::*;
#(
  parameter int MEM_WORDS   = 2048,
  parameter int STACK_DEPTH = 8,
  parameter int AW          = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv_en,
  input  logic              lo_we,
  input  logic [7:0]        lo_data,
  input  logic              br_en,
  input  logic              br_link,
  input  logic [10:0]       br_tgt,
  input  logic              ret_en,
  input  logic              irq_en,
  input  logic              hold_we,
  input  logic [4:0]        hold_data,
  output logic [12:0]       pc_q,
  output logic [AW-1:0]     fetch_addr,
  output logic [4:0]        hold_q
);
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] push_val;
  logic [PC_W-1:0] pop_val;
  logic            push;
  logic            pop;

  pcu_sel u_sel (
    .pc_q     (pc_q),
    .hold_q   (hold_q),
    .adv_en   (adv_en),
    .lo_we    (lo_we),
    .lo_data  (lo_data),
    .br_en    (br_en),
    .br_link  (br_link),
    .br_tgt   (br_tgt),
    .ret_en   (ret_en),
    .irq_en   (irq_en),
    .pop_val  (pop_val),
    .pc_nxt   (pc_nxt),
    .push     (push),
    .pop      (pop),
    .push_val (push_val)
  );

  pcu_rstack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .push_val (push_val),
    .top_val  (pop_val)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_VEC;
    else     pc_q <= pc_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst)          hold_q <= '0;
    else if (hold_we) hold_q <= hold_data;
  end

  assign fetch_addr = pc_q[AW-1:0];

  // R2: lone advance steps by one, wrapping at 13 bits
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !lo_we && !br_en && !ret_en && !irq_en) |=> pc_q == $past(pc_q) + 13'd1);
  // R6: interrupt entry lands on the vector
  a_r6_vector: assert property (@(posedge clk) disable iff (rst)
    irq_en |=> pc_q == IRQ_VEC);
  // R4: page bits of a jump come from latch bits 4:3
  a_r4_page: assert property (@(posedge clk) disable iff (rst)
    (br_en && !ret_en && !irq_en) |=> pc_q[12:11] == $past(hold_q[4:3]));
  // R9: latch holds unless written
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !hold_we |=> $stable(hold_q));
endmodule

// File: tb/pcu_top_bench.sv
`timescale 1ns/100ps
module pcu_top_bench;
  localparam int MEM_WORDS = 1024;
  localparam int AW = $clog2(MEM_WORDS);

  localparam int OP_NOP = 0, OP_INC = 1, OP_LOW = 2, OP_HOLD = 3,
                 OP_JMP = 4, OP_CALL = 5, OP_RET = 6, OP_IRQ = 7;

  // {op[3:0], arg[10:0], expected pc[12:0]}
  localparam logic [27:0] VEC [14] = '{
    {4'd1, 11'h000, 13'h0001},
    {4'd1, 11'h000, 13'h0002},
    {4'd3, 11'h01A, 13'h0002},
    {4'd2, 11'h034, 13'h1A34},
    {4'd4, 11'h123, 13'h1923},
    {4'd5, 11'h055, 13'h1855},
    {4'd1, 11'h000, 13'h1856},
    {4'd7, 11'h000, 13'h0004},
    {4'd6, 11'h000, 13'h1856},
    {4'd6, 11'h000, 13'h1924},
    {4'd3, 11'h000, 13'h1924},
    {4'd4, 11'h7FF, 13'h07FF},
    {4'd1, 11'h000, 13'h0800},
    {4'd2, 11'h0FF, 13'h00FF}
  };

  logic clk = 1'b0;
  logic rst;
  logic adv_en, lo_we, br_en, br_link, ret_en, irq_en, hold_we;
  logic [7:0]  lo_data;
  logic [10:0] br_tgt;
  logic [4:0]  hold_data;
  logic [12:0] pc_q;
  logic [AW-1:0] fetch_addr;
  logic [4:0]  hold_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcu_top #(.MEM_WORDS(MEM_WORDS)) u_pcu_top (
    .clk(clk), .rst(rst), .adv_en(adv_en), .lo_we(lo_we), .lo_data(lo_data),
    .br_en(br_en), .br_link(br_link), .br_tgt(br_tgt), .ret_en(ret_en),
    .irq_en(irq_en), .hold_we(hold_we), .hold_data(hold_data),
    .pc_q(pc_q), .fetch_addr(fetch_addr), .hold_q(hold_q)
  );

  task automatic idle();
    adv_en = 0; lo_we = 0; br_en = 0; br_link = 0; ret_en = 0; irq_en = 0;
    hold_we = 0; lo_data = '0; br_tgt = '0; hold_data = '0;
  endtask

  task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with inputs idle.
  task automatic do_op(input int op, input logic [10:0] arg);
    case (op)
      OP_INC:  adv_en = 1;
      OP_LOW:  begin lo_we = 1; lo_data = arg[7:0]; end
      OP_HOLD: begin hold_we = 1; hold_data = arg[4:0]; end
      OP_JMP:  begin br_en = 1; br_tgt = arg; end
      OP_CALL: begin br_en = 1; br_link = 1; br_tgt = arg; end
      OP_RET:  ret_en = 1;
      OP_IRQ:  irq_en = 1;
      default: ;
    endcase
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst = 1;
    idle();
    @(negedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pc", pc_q, 13'h0000);
    chk("R1 hold", {8'h00, hold_q}, 13'h0000);

    // Table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 14; i++) begin
      do_op(int'(VEC[i][27:24]), VEC[i][23:13]);
      chk($sformatf("R3/R4/R5/R6/R7 vector %0d", i), pc_q, VEC[i][12:0]);
    end
    chk("R9 hold after table", {8'h00, hold_q}, 13'h0000);

    // R8 stack overwrite and empty-pop wrap
    do_reset();
    for (int k = 1; k <= 9; k++) begin
      do_op(OP_CALL, 11'(k * 16));
      chk("R5 call target", pc_q, 13'(k * 16));
    end
    for (int j = 0; j < 8; j++) begin
      do_op(OP_RET, '0);
      chk("R8 pop order", pc_q, 13'((8 - j) * 16 + 1));
    end
    do_op(OP_RET, '0);
    chk("R8 empty pop wraps", pc_q, 13'h0081);

    // R11 priority
    do_reset();
    do_op(OP_INC, '0); do_op(OP_INC, '0); do_op(OP_INC, '0);
    chk("R2 advance", pc_q, 13'h0003);
    irq_en = 1; ret_en = 1; br_en = 1; lo_we = 1; adv_en = 1; br_tgt = 11'h200; lo_data = 8'h77;
    @(negedge clk); idle();
    chk("R11 irq wins", pc_q, 13'h0004);
    ret_en = 1; br_en = 1; lo_we = 1; adv_en = 1; br_tgt = 11'h200; lo_data = 8'h77;
    @(negedge clk); idle();
    chk("R11 return over jump", pc_q, 13'h0003);
    br_en = 1; lo_we = 1; adv_en = 1; br_tgt = 11'h200; lo_data = 8'h77;
    @(negedge clk); idle();
    chk("R11 jump over low write", pc_q, 13'h0200);
    lo_we = 1; adv_en = 1; lo_data = 8'h77;
    @(negedge clk); idle();
    chk("R11 low write over advance", pc_q, 13'h0077);

    // R9 latch survives call and return
    do_op(OP_HOLD, 11'h00A);
    chk("R9 readback", {8'h00, hold_q}, 13'h000A);
    do_op(OP_CALL, 11'h100);
    chk("R4 page from latch", pc_q, 13'h0900);
    chk("R9 hold after push", {8'h00, hold_q}, 13'h000A);
    do_op(OP_RET, '0);
    chk("R7 return", pc_q, 13'h0078);
    chk("R9 hold after pop", {8'h00, hold_q}, 13'h000A);

    // R3 with old latch value when both written together
    hold_we = 1; hold_data = 5'h03; lo_we = 1; lo_data = 8'h11;
    @(negedge clk); idle();
    chk("R3 uses prior latch", pc_q, 13'h0A11);

    // R10 fetch wrap, R2 13-bit wrap
    do_op(OP_HOLD, 11'h004);
    do_op(OP_LOW, 11'h000);
    chk("R10 pc", pc_q, 13'h0400);
    chk("R10 fetch wraps", {3'b000, fetch_addr}, 13'h0000);
    do_op(OP_HOLD, 11'h01F);
    do_op(OP_LOW, 11'h0FF);
    chk("R10 fetch top", {3'b000, fetch_addr}, 13'h03FF);
    do_op(OP_INC, '0);
    chk("R2 wrap at 13 bits", pc_q, 13'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule